// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory Guard

This block sits between a simple single-cycle memory bus and an on-chip synchronous RAM. It protects every stored word against radiation-induced bit flips. On a write it derives Hamming check bits and an overall parity bit from the data, and stores them beside the data at the same address. On a read it recomputes the check bits from the returned data and forms a syndrome. It then corrects any single flipped bit before the word reaches the bus, and flags any double flip as uncorrectable.

Errors are reported in two ways. Each read response carries its own correctable and uncorrectable flags. Sticky status bits, together with per-kind interrupt enables, drive a level interrupt. A small register set on an AXI4-Lite slave controls the checking and reports errors. The slave runs on the same clock as the memory bus. The register set holds the checking enable, the interrupt enables, the sticky status and the word address of the first failing read. Partial-word writes and background scrubbing are not provided.

Top module: `ecc_mem_guard`

## Requirements
- R1: A write (`mem_en`=1, `mem_we`=1) stores the word. A read (`mem_en`=1, `mem_we`=0) raises `mem_rvalid` for exactly the next cycle. In that cycle `mem_rdata` holds the last data written to that address, and `mem_ce`=`mem_ue`=0 when the stored word is intact.
- R2: Each stored word has the data in bits DW-1:0, the Hamming bits h in bits DW+HB-1:DW and the overall parity in bit DW+HB, where HB is the least r with 2^r >= DW+r+1 (6 for 32-bit data). Data bit k is word bit DW-1-k, so bit 0 is the most significant bit. It takes the k-th codeword position that is not a power of two, counting from 3. h is the XOR of the positions of all set data bits. The parity bit makes the whole stored word even.
- R3: When exactly one data bit of a stored word is flipped, the read returns the original data with `mem_ce`=1 and `mem_ue`=0.
- R4: When exactly one Hamming bit or the parity bit is flipped, the read returns the data unchanged with `mem_ce`=1 and `mem_ue`=0.
- R5: When any two bits of a stored word are flipped, the read shows `mem_ue`=1 and `mem_ce`=0. The two flags are never both high.
- R6: With the enable bit at 0, reads return the stored data bits uncorrected and both flags stay 0, and no status bit is set. Writes still store valid check bits, so the same words read clean once checking is enabled again.
- R7: The status register at offset 0x4 holds a sticky correctable bit (bit 0) and a sticky uncorrectable bit (bit 1). A flagged read sets the matching bit. Writing 1 to a bit clears it.
- R8: The register at offset 0x8 captures the word address of a flagged read only while both status bits are clear. It holds that address until the status is cleared. Writes to it are ignored.
- R9: The control register at offset 0x0 has the enable in bit 0, the correctable interrupt enable in bit 1 and the uncorrectable interrupt enable in bit 2. `irq` is high exactly when some sticky status bit is set together with its enable.
- R10: After reset the control register reads 1, status and failing address read 0, and `irq` and `mem_rvalid` are 0.
- R11: Each AXI4-Lite write produces one `s_bvalid` beat and each read one `s_rvalid` beat, both with response code 0 (OKAY).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by memory bus and register slave |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_en | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | AW | Word address |
| mem_wdata | input | DW | Write data |
| mem_rdata | output | DW | Corrected read data |
| mem_rvalid | output | 1 | Read response valid, one cycle after the request |
| mem_ce | output | 1 | Response carried a corrected single error |
| mem_ue | output | 1 | Response carried an uncorrectable error |
| s_awaddr | input | 4 | Register write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Register write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted |
| s_araddr | input | 4 | Register read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Register read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accepted |
| irq | output | 1 | Level interrupt |

## Verification
A wrong participation pattern, or a wrong stored field order, makes words written through the bus disagree with codewords built independently in the bench. It also sends single-bit corrections to the wrong bit. Both show on `mem_rdata` and `mem_ce` in the response cycle right after the read. A stale sticky bit or a wrongly captured failing address shows at the next register read. A wrong interrupt mask shows on `irq` in the cycle after the status or control change. A decode that confuses odd and even overall parity swaps `mem_ce` and `mem_ue` on the very first injected flip.

// File: rtl/ecc_guard_pkg.sv
`timescale 1ns/1ps
package ecc_guard_pkg;

  // number of Hamming bits needed to cover dw data bits
  function automatic int unsigned hbits_for(int unsigned dw);
    int unsigned res = 0;
    for (int unsigned r = 1; r < 10; r++) begin
      if (res == 0 && (32'd1 << r) >= dw + r + 1) res = r;
    end
    return res;
  endfunction

  // codeword position of data bit k: k-th non-power-of-two from 3 upward
  function automatic int unsigned data_pos(int unsigned k);
    int unsigned seen = 0;
    int unsigned res = 0;
    for (int unsigned q = 3; q < 128; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (seen == k) res = q;
        seen++;
      end
    end
    return res;
  endfunction

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_STATUS = 2'd1,
    REG_FADDR  = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/ecc_enc.sv
`timescale 1ns/1ps
module ecc_enc #(
  parameter int unsigned DW = 32,
  parameter int unsigned HB = 6
) (
  input  logic [DW-1:0] data,
  output logic [HB-1:0] ham,
  output logic          par
);
  logic [HB-1:0] contrib [DW];

  for (genvar k = 0; k < DW; k++) begin : g_bit
    localparam int unsigned POS = ecc_guard_pkg::data_pos(k);
    assign contrib[k] = data[DW-1-k] ? HB'(POS) : '0;
  end

  always_comb begin
    ham = '0;
    for (int k = 0; k < DW; k++) ham = ham ^ contrib[k];
  end

  assign par = ^{data, ham};
endmodule

// File: rtl/ecc_dec.sv
`timescale 1ns/1ps
module ecc_dec #(
  parameter int unsigned DW = 32,
  parameter int unsigned HB = 6
) (
  input  logic [DW-1:0] rd_data,
  input  logic [HB-1:0] rd_ham,
  input  logic          rd_par,
  output logic [DW-1:0] fix_data,
  output logic          err_single,
  output logic          err_double
);
  logic [HB-1:0] ham_new;
  logic          par_new;
  logic [HB-1:0] syndrome;
  logic          odd_weight;
  logic [DW-1:0] flip;
  logic          hit_data;
  logic          hit_check;

  ecc_enc #(.DW(DW), .HB(HB)) u_recode (
    .data (rd_data),
    .ham  (ham_new),
    .par  (par_new)
  );

  assign syndrome = rd_ham ^ ham_new;
  // parity of whole stored word = par_new ^ parity(syndrome) ^ rd_par
  assign odd_weight = par_new ^ (^syndrome) ^ rd_par;

  for (genvar k = 0; k < DW; k++) begin : g_hit
    localparam int unsigned POS = ecc_guard_pkg::data_pos(k);
    assign flip[DW-1-k] = (syndrome == HB'(POS));
  end

  assign hit_data   = |flip;
  assign hit_check  = (syndrome != '0) && ((syndrome & (syndrome - HB'(1))) == '0);
  assign err_single = odd_weight && ((syndrome == '0) || hit_check || hit_data);
  assign err_double = (syndrome != '0) && !err_single;
  assign fix_data   = rd_data ^ (err_single ? flip : '0);
endmodule

// File: rtl/ecc_store.sv
`timescale 1ns/1ps
module ecc_store #(
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 39
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wword,
  output logic [CW-1:0] rword
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wword;
      else    rword     <= mem[addr];
    end
  end
endmodule

// File: rtl/ecc_csr.sv
`timescale 1ns/1ps
module ecc_csr #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    s_awaddr,
  input  logic          s_awvalid,
  output logic          s_awready,
  input  logic [31:0]   s_wdata,
  input  logic          s_wvalid,
  output logic          s_wready,
  output logic [1:0]    s_bresp,
  output logic          s_bvalid,
  input  logic          s_bready,
  input  logic [3:0]    s_araddr,
  input  logic          s_arvalid,
  output logic          s_arready,
  output logic [31:0]   s_rdata,
  output logic [1:0]    s_rresp,
  output logic          s_rvalid,
  input  logic          s_rready,
  input  logic          evt_ce,
  input  logic          evt_ue,
  input  logic [AW-1:0] evt_addr,
  output logic          ecc_on,
  output logic          st_ce,
  output logic          st_ue,
  output logic [AW-1:0] fail_addr,
  output logic          irq
);
  import ecc_guard_pkg::*;

  logic ie_ce, ie_ue;
  logic wr_go, ar_go;
  logic clr_ce, clr_ue;
  reg_sel_e wsel, rsel;
  logic [31:0] rmux;
  logic unused_bits;

  assign unused_bits = ^{s_awaddr[1:0], s_araddr[1:0], s_wdata[31:3]};

  assign wsel      = reg_sel_e'(s_awaddr[3:2]);
  assign rsel      = reg_sel_e'(s_araddr[3:2]);
  assign wr_go     = s_awvalid && s_wvalid && !s_bvalid;
  assign s_awready = wr_go;
  assign s_wready  = wr_go;
  assign ar_go     = s_arvalid && !s_rvalid;
  assign s_arready = !s_rvalid;
  assign s_bresp   = RESP_OKAY;
  assign s_rresp   = RESP_OKAY;

  assign clr_ce = wr_go && (wsel == REG_STATUS) && s_wdata[0];
  assign clr_ue = wr_go && (wsel == REG_STATUS) && s_wdata[1];

  always_comb begin
    rmux = '0;
    case (rsel)
      REG_CTRL:   rmux[2:0]    = {ie_ue, ie_ce, ecc_on};
      REG_STATUS: rmux[1:0]    = {st_ue, st_ce};
      REG_FADDR:  rmux[AW-1:0] = fail_addr;
      default:    rmux         = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecc_on    <= 1'b1;
      ie_ce     <= 1'b0;
      ie_ue     <= 1'b0;
      st_ce     <= 1'b0;
      st_ue     <= 1'b0;
      fail_addr <= '0;
      s_bvalid  <= 1'b0;
      s_rvalid  <= 1'b0;
      s_rdata   <= '0;
    end else begin
      if (wr_go && wsel == REG_CTRL) {ie_ue, ie_ce, ecc_on} <= s_wdata[2:0];
      st_ce <= (st_ce && !clr_ce) || evt_ce;
      st_ue <= (st_ue && !clr_ue) || evt_ue;
      if ((evt_ce || evt_ue) && !(st_ce || st_ue)) fail_addr <= evt_addr;
      if (wr_go)         s_bvalid <= 1'b1;
      else if (s_bready) s_bvalid <= 1'b0;
      if (ar_go) begin
        s_rvalid <= 1'b1;
        s_rdata  <= rmux;
      end else if (s_rready) begin
        s_rvalid <= 1'b0;
      end
    end
  end

  assign irq = (st_ce && ie_ce) || (st_ue && ie_ue);
endmodule

// File: rtl/ecc_mem_guard.sv
`timescale 1ns/1ps
module ecc_mem_guard #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_en,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] mem_rdata,
  output logic          mem_rvalid,
  output logic          mem_ce,
  output logic          mem_ue,
  input  logic [3:0]    s_awaddr,
  input  logic          s_awvalid,
  output logic          s_awready,
  input  logic [31:0]   s_wdata,
  input  logic          s_wvalid,
  output logic          s_wready,
  output logic [1:0]    s_bresp,
  output logic          s_bvalid,
  input  logic          s_bready,
  input  logic [3:0]    s_araddr,
  input  logic          s_arvalid,
  output logic          s_arready,
  output logic [31:0]   s_rdata,
  output logic [1:0]    s_rresp,
  output logic          s_rvalid,
  input  logic          s_rready,
  output logic          irq
);
  localparam int unsigned HB = ecc_guard_pkg::hbits_for(DW);
  localparam int unsigned CW = DW + HB + 1;

  logic [HB-1:0] w_ham;
  logic          w_par;
  logic [CW-1:0] wword, rword;
  logic          rd_pend;
  logic [AW-1:0] rd_addr_q;
  logic [DW-1:0] dec_data;
  logic          dec_single, dec_double;
  logic          ecc_on, st_ce, st_ue;
  logic [AW-1:0] fail_addr;
  logic          evt_ce, evt_ue;

  ecc_enc #(.DW(DW), .HB(HB)) u_enc (
    .data (mem_wdata),
    .ham  (w_ham),
    .par  (w_par)
  );

  assign wword = {w_par, w_ham, mem_wdata};

  ecc_store #(.AW(AW), .CW(CW)) u_store (
    .clk   (clk),
    .en    (mem_en),
    .we    (mem_we),
    .addr  (mem_addr),
    .wword (wword),
    .rword (rword)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_pend <= mem_en && !mem_we;
      if (mem_en && !mem_we) rd_addr_q <= mem_addr;
    end
  end

  ecc_dec #(.DW(DW), .HB(HB)) u_dec (
    .rd_data    (rword[DW-1:0]),
    .rd_ham     (rword[DW+HB-1:DW]),
    .rd_par     (rword[CW-1]),
    .fix_data   (dec_data),
    .err_single (dec_single),
    .err_double (dec_double)
  );

  assign evt_ce     = rd_pend && ecc_on && dec_single;
  assign evt_ue     = rd_pend && ecc_on && dec_double;
  assign mem_rvalid = rd_pend;
  assign mem_ce     = evt_ce;
  assign mem_ue     = evt_ue;
  assign mem_rdata  = ecc_on ? dec_data : rword[DW-1:0];

  ecc_csr #(.AW(AW)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_awaddr  (s_awaddr),
    .s_awvalid (s_awvalid),
    .s_awready (s_awready),
    .s_wdata   (s_wdata),
    .s_wvalid  (s_wvalid),
    .s_wready  (s_wready),
    .s_bresp   (s_bresp),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_araddr  (s_araddr),
    .s_arvalid (s_arvalid),
    .s_arready (s_arready),
    .s_rdata   (s_rdata),
    .s_rresp   (s_rresp),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .evt_ce    (evt_ce),
    .evt_ue    (evt_ue),
    .evt_addr  (rd_addr_q),
    .ecc_on    (ecc_on),
    .st_ce     (st_ce),
    .st_ue     (st_ue),
    .fail_addr (fail_addr),
    .irq       (irq)
  );
endmodule

// File: rtl/ecc_mem_guard_chk.sv
`timescale 1ns/1ps
module ecc_mem_guard_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rvalid,
  input logic          mem_ce,
  input logic          mem_ue,
  input logic          ecc_on,
  input logic          st_ce,
  input logic          st_ue,
  input logic [AW-1:0] fail_addr,
  input logic          irq
);
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_ce && mem_ue));

  a_r1_flags_need_response: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce || mem_ue) |-> mem_rvalid);

  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_on |-> !(mem_ce || mem_ue));

  a_r7_ce_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce |=> st_ce);

  a_r7_ue_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ue |=> st_ue);

  a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_ce || st_ue));

  a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_ce || st_ue) && $past(st_ce || st_ue)) |-> $stable(fail_addr));
endmodule

bind ecc_mem_guard ecc_mem_guard_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_rvalid (mem_rvalid),
  .mem_ce     (mem_ce),
  .mem_ue     (mem_ue),
  .ecc_on     (ecc_on),
  .st_ce      (st_ce),
  .st_ue      (st_ue),
  .fail_addr  (fail_addr),
  .irq        (irq)
);

// File: tb/sim_ecc_mem_guard.sv
`timescale 1ns/1ps
module sim_ecc_mem_guard;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int HB = 6;
  localparam int CW = DW + HB + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          mem_en = 1'b0, mem_we = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [DW-1:0] mem_wdata = '0;
  logic [DW-1:0] mem_rdata;
  logic          mem_rvalid, mem_ce, mem_ue;
  logic [3:0]    s_awaddr = '0, s_araddr = '0;
  logic          s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
  logic [31:0]   s_wdata = '0;
  logic          s_awready, s_wready, s_bvalid, s_arready, s_rvalid, irq;
  logic [1:0]    s_bresp, s_rresp;
  logic [31:0]   s_rdata;

  ecc_mem_guard #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .mem_ce(mem_ce), .mem_ue(mem_ue),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(1'b1),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(1'b1),
    .irq(irq)
  );

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;
  logic [DW-1:0] model [256];
  logic [AW-1:0] waddr [48];

  function automatic logic [CW-1:0] bench_code(logic [DW-1:0] d);
    logic [HB-1:0] h = '0;
    int k = 0;
    for (int q = 1; k < DW; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (d[DW-1-k]) h = h ^ HB'(q);
        k++;
      end
    end
    return {^{d, h}, h, d};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  task automatic mem_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    mem_en = 1; mem_we = 1; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_en = 0; mem_we = 0;
    model[a] = d;
  endtask

  task automatic mem_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                          output logic ce, output logic ue, output logic rv);
    @(negedge clk);
    mem_en = 1; mem_we = 0; mem_addr = a;
    @(negedge clk);
    mem_en = 0;
    d = mem_rdata; ce = mem_ce; ue = mem_ue; rv = mem_rvalid;
  endtask

  task automatic axi_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_awvalid = 1; s_wvalid = 1;
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    check(s_bvalid && s_bresp == 2'b00, "R11 write response", {s_bvalid, s_bresp}, 3'b100);
  endtask

  task automatic axi_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    @(negedge clk);
    s_arvalid = 0;
    d = s_rdata;
    check(s_rvalid && s_rresp == 2'b00, "R11 read response", {s_rvalid, s_rresp}, 3'b100);
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [CW-1:0] cw);
    @(negedge clk);
    u0.u_store.mem[a] = cw;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic ce, ue, rv;
    logic [31:0] r;
    logic [CW-1:0] cw;
    logic [AW-1:0] first_a;
    void'($urandom(32'd4711));

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check(!mem_rvalid && !irq, "R10 rvalid/irq after reset", {mem_rvalid, irq}, 0);
    axi_rd(4'h0, r); check(r == 32'd1, "R10 control reset", r, 1);
    axi_rd(4'h4, r); check(r == 32'd0, "R10 status reset", r, 0);
    axi_rd(4'h8, r); check(r == 32'd0, "R10 fail address reset", r, 0);

    // R1 random write then read back
    for (int i = 0; i < 48; i++) begin
      waddr[i] = AW'($urandom % 200);
      mem_write(waddr[i], $urandom);
    end
    for (int i = 0; i < 48; i++) begin
      mem_read(waddr[i], d, ce, ue, rv);
      check(rv && d == model[waddr[i]] && !ce && !ue, "R1 clean read",
            {rv, ce, ue, d}, {3'b100, model[waddr[i]]});
    end
    mem_write(8'd250, 32'hDEAD_BEEF);
    mem_read(8'd250, d, ce, ue, rv);
    check(rv && d == 32'hDEAD_BEEF, "R1 directed read", d, 32'hDEAD_BEEF);
    @(negedge clk);
    check(!mem_rvalid, "R1 rvalid lasts one cycle", mem_rvalid, 0);

    // R2 codewords built by the bench read back as clean
    for (int i = 0; i < 6; i++) begin
      d = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF : $urandom;
      model[8'd240 + i] = d;
      inject(8'(240 + i), bench_code(d));
      mem_read(8'(240 + i), d, ce, ue, rv);
      check(d == model[8'd240 + i] && !ce && !ue, "R2 bench codeword clean",
            {ce, ue, d}, {2'b00, model[8'd240 + i]});
    end

    // R3 single data-bit flips, including both ends of the word
    first_a = waddr[0];
    for (int i = 0; i < 10; i++) begin
      int b;
      b = (i == 0) ? 0 : (i == 1) ? DW - 1 : int'($urandom % DW);
      cw = bench_code(model[waddr[i]]);
      cw[b] = ~cw[b];
      inject(waddr[i], cw);
      mem_read(waddr[i], d, ce, ue, rv);
      check(d == model[waddr[i]] && ce && !ue, "R3 data flip corrected",
            {ce, ue, d}, {2'b10, model[waddr[i]]});
    end
    axi_rd(4'h4, r); check(r == 32'd1, "R7 correctable sticky", r, 1);
    axi_rd(4'h8, r); check(r == 32'(first_a), "R8 first fail address", r, 32'(first_a));
    axi_wr(4'h8, 32'hFF);
    axi_rd(4'h8, r); check(r == 32'(first_a), "R8 fail address write ignored", r, 32'(first_a));
    axi_wr(4'h4, 32'h0);
    axi_rd(4'h4, r); check(r == 32'd1, "R7 write 0 keeps status", r, 1);
    axi_wr(4'h4, 32'h1);
    axi_rd(4'h4, r); check(r == 32'd0, "R7 write 1 clears", r, 0);

    // R4 flips in each Hamming bit and the parity bit
    first_a = waddr[12];
    for (int j = 0; j <= HB; j++) begin
      cw = bench_code(model[waddr[12 + j]]);
      cw[DW + j] = ~cw[DW + j];
      inject(waddr[12 + j], cw);
      mem_read(waddr[12 + j], d, ce, ue, rv);
      check(d == model[waddr[12 + j]] && ce && !ue, "R4 check bit flip",
            {ce, ue, d}, {2'b10, model[waddr[12 + j]]});
    end

    // R5 double flips anywhere in the stored word
    for (int i = 0; i < 12; i++) begin
      int b1, b2;
      b1 = int'($urandom % CW);
      b2 = (b1 + 1 + int'($urandom % (CW - 1))) % CW;
      if (i == 0) begin b1 = 0; b2 = CW - 1; end
      cw = bench_code(model[waddr[24 + i]]);
      cw[b1] = ~cw[b1];
      cw[b2] = ~cw[b2];
      inject(waddr[24 + i], cw);
      mem_read(waddr[24 + i], d, ce, ue, rv);
      check(ue && !ce, "R5 double flip flagged", {ce, ue}, 2'b01);
    end
    axi_rd(4'h4, r); check(r == 32'd3, "R7 both sticky bits", r, 3);
    axi_rd(4'h8, r); check(r == 32'(first_a), "R8 address held", r, 32'(first_a));

    // R9 interrupt masking
    check(!irq, "R9 irq masked", irq, 0);
    axi_wr(4'h0, 32'h5);
    check(irq, "R9 irq on uncorrectable", irq, 1);
    axi_wr(4'h4, 32'h2);
    check(!irq, "R9 irq drops, ce not enabled", irq, 0);
    axi_wr(4'h0, 32'h3);
    check(irq, "R9 irq on correctable", irq, 1);
    axi_wr(4'h4, 32'h3);
    check(!irq, "R9 irq cleared", irq, 0);

    // R6 checking disabled
    axi_wr(4'h0, 32'h6);
    cw = bench_code(model[waddr[40]]);
    cw[5] = ~cw[5];
    inject(waddr[40], cw);
    mem_read(waddr[40], d, ce, ue, rv);
    check(d == (model[waddr[40]] ^ 32'h20) && !ce && !ue, "R6 raw data when off",
          {ce, ue, d}, {2'b00, model[waddr[40]] ^ 32'h20});
    cw[9] = ~cw[9];
    inject(waddr[40], cw);
    mem_read(waddr[40], d, ce, ue, rv);
    check(!ce && !ue, "R6 no flags when off", {ce, ue}, 0);
    mem_write(8'd222, 32'h1234_5678);
    axi_rd(4'h4, r); check(r == 32'd0 && !irq, "R6 no status when off", {irq, r}, 0);
    axi_wr(4'h0, 32'h1);
    mem_read(8'd222, d, ce, ue, rv);
    check(d == 32'h1234_5678 && !ce && !ue, "R6 check bits written while off",
          {ce, ue, d}, {2'b00, 32'h1234_5678});

    done = 1;
    summary();
    $finish;
  end
endmodule